// File: doc/BRIEF.md
# Boundary Register Cell Chain

This block is a parameterised chain of boundary register cells, each sitting between one pad-side signal and the core. Every cell has two storage stages. A capture/shift flop either samples the cell's parallel input or takes the serial bit from its neighbour. A separate update stage holds the value the cell drives when the chain is in test mode. The two stages have independent enables, so a new pattern can be shifted through the chain while the previously updated pattern keeps driving the outputs.

In normal mode every cell is transparent: its parallel input goes straight to its output. A test controller drives the shared control inputs. It loads a pattern serially, or captures the live inputs with a single enabled clock. It then pulses the update enable to move the captured or shifted values into the update stage, and raises the test select so that the update stage drives the outputs. Each cell also holds an output-enable bit in its update stage. This lets the controller put all driven outputs into an inactive state and keep them there across later shifting.

All control inputs are sampled on the rising edge of one test clock, qualified by the enables. An asynchronous active-low reset is released through a two-stage synchroniser.

Top module: `bsc_register`

## Requirements
- R1: While reset is asserted, and until the first enabled operation after it, every capture flop reads 0, every update bit reads the parameter UPD_RESET (default all 0), and every output-enable bit reads 1. So `ser_out` is 0, `pin_out` equals UPD_RESET in test mode, and `out_en` is 1.
- R2: With `test_sel` = 0, `pin_out[i]` equals `pin_in[i]` in the same cycle for every cell.
- R3: On a clock edge with `cap_en` = 1 and `shift_sel` = 1, cell 0 takes `ser_in` and cell i takes the previous value of cell i-1.
- R4: On a clock edge with `cap_en` = 1 and `shift_sel` = 0, every capture flop i loads `pin_in[i]`.
- R5: On a clock edge with `cap_en` = 0, the capture flops keep their values whatever `shift_sel`, `ser_in` and `pin_in` are.
- R6: On a clock edge with `upd_en` = 1, each update bit loads the capture flop's value from before that edge, and each output-enable bit loads the inverse of `hiz_req`. With `upd_en` = 0, both hold.
- R7: With `test_sel` = 1, `pin_out` equals the update stage. Shifting or capturing with `upd_en` = 0 leaves `pin_out` unchanged.
- R8: `ser_out` always equals the capture flop of cell WIDTH-1 and never the update stage.
- R9: `out_en` is 1 in normal mode. In test mode it equals the output-enable bit last loaded by an update.
- R10: When `cap_en` and `upd_en` are both 1 on one edge, the update stage receives the capture value from before that edge, not the newly shifted or captured one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all stages act on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pin_in | input | WIDTH | Parallel input of each cell (pad or core side) |
| ser_in | input | 1 | Serial input into cell 0 |
| shift_sel | input | 1 | 1 = shift, 0 = capture, when `cap_en` is 1 |
| cap_en | input | 1 | Clock enable of the capture/shift stage |
| upd_en | input | 1 | Clock enable of the update stage |
| hiz_req | input | 1 | Output-inactive request, latched by `upd_en` |
| test_sel | input | 1 | 1 = update stage drives outputs, 0 = transparent |
| pin_out | output | WIDTH | Parallel output of each cell |
| out_en | output | WIDTH | Output-enable of each cell (1 = drive) |
| ser_out | output | 1 | Serial output of cell WIDTH-1 |

## Verification
A walking serial pattern, then a full shift-out, shows whether bits move one cell per enabled edge in the right direction. A capture of an alternating parallel word shows whether the load path is kept apart from the shift path. Shifting with test mode on, and a pulse with both enables set, separate the case where the update stage really is isolated from the case where it follows the capture stage. Long random mixes of all control inputs cover the combinations in between, including edges with the capture enable low.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  typedef enum logic [1:0] {
    CAP_HOLD  = 2'd0,
    CAP_LOAD  = 2'd1,
    CAP_SHIFT = 2'd2
  } cap_op_e;

  function automatic cap_op_e decode_cap_op(input logic en, input logic shift);
    if (!en)        return CAP_HOLD;
    else if (shift) return CAP_SHIFT;
    else            return CAP_LOAD;
  endfunction

endpackage

// File: rtl/bsc_rst_sync.sv
module bsc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;
  logic [LAST:0] sync_d;

  always_comb begin
    sync_d = {sync_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[LAST];

endmodule

// File: rtl/bsc_cell.sv
module bsc_cell
  import bsc_pkg::*;
#(
  parameter logic UPD_RST = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic ser_in,
  input  logic shift_sel,
  input  logic cap_en,
  input  logic upd_en,
  input  logic hiz_req,
  input  logic test_sel,
  output logic pin_out,
  output logic out_en,
  output logic ser_out
);

  cap_op_e cap_op;
  logic    cap_q, cap_d;
  logic    upd_q, upd_d;
  logic    oe_q, oe_d;

  // capture/shift stage: next-state
  always_comb begin
    cap_op = decode_cap_op(cap_en, shift_sel);
    unique case (cap_op)
      CAP_SHIFT: cap_d = ser_in;
      CAP_LOAD:  cap_d = pin_in;
      default:   cap_d = cap_q;
    endcase
  end

  // update stage: next-state
  always_comb begin
    upd_d = upd_q;
    oe_d  = oe_q;
    if (upd_en) begin
      upd_d = cap_q;
      oe_d  = ~hiz_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= 1'b0;
    else        cap_q <= cap_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= UPD_RST;
      oe_q  <= 1'b1;
    end else begin
      upd_q <= upd_d;
      oe_q  <= oe_d;
    end
  end

  // output selection
  always_comb begin
    pin_out = test_sel ? upd_q : pin_in;
    out_en  = test_sel ? oe_q : 1'b1;
  end

  assign ser_out = cap_q;

  a_r5_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(cap_q));

  a_r3_shift_take: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && shift_sel) |=> (cap_q == $past(ser_in)));

  a_r4_capture_take: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !shift_sel) |=> (cap_q == $past(pin_in)));

  a_r6_upd_take: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (upd_q == $past(cap_q)) && (oe_q == !$past(hiz_req)));

  a_r7_upd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(upd_q) && $stable(oe_q));

  a_r7_drive_still: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && test_sel && $past(test_sel) && $past(!upd_en)) |-> $stable(pin_out));

endmodule

// File: rtl/bsc_register.sv
module bsc_register #(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] UPD_RESET = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  input  logic             ser_in,
  input  logic             shift_sel,
  input  logic             cap_en,
  input  logic             upd_en,
  input  logic             hiz_req,
  input  logic             test_sel,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] out_en,
  output logic             ser_out
);
  localparam int LINKS = WIDTH + 1;

  logic             rst_sync_n;
  logic [LINKS-1:0] link;

  bsc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign link[0] = ser_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    bsc_cell #(.UPD_RST(UPD_RESET[i])) u_cell (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .pin_in    (pin_in[i]),
      .ser_in    (link[i]),
      .shift_sel (shift_sel),
      .cap_en    (cap_en),
      .upd_en    (upd_en),
      .hiz_req   (hiz_req),
      .test_sel  (test_sel),
      .pin_out   (pin_out[i]),
      .out_en    (out_en[i]),
      .ser_out   (link[i+1])
    );
  end

  assign ser_out = link[WIDTH];

  a_r8_serial_moves: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cap_en && shift_sel) |=> (ser_out == $past(link[WIDTH-1])));

  a_r2_transparent: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !test_sel |-> (pin_out == pin_in) && (&out_en));

endmodule

// File: tb/sim_bsc_register.sv
module sim_bsc_register;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] pin_in;
  logic         ser_in, shift_sel, cap_en, upd_en, hiz_req, test_sel;
  logic [W-1:0] pin_out, out_en;
  logic         ser_out;

  int checks = 0;
  int failures = 0;

  logic [W-1:0] cap_m, upd_m, oe_m;

  always #10 clk = ~clk;

  bsc_register #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .ser_in(ser_in),
    .shift_sel(shift_sel), .cap_en(cap_en), .upd_en(upd_en),
    .hiz_req(hiz_req), .test_sel(test_sel), .pin_out(pin_out),
    .out_en(out_en), .ser_out(ser_out)
  );

  function automatic logic [W-1:0] exp_pin_out();
    return test_sel ? upd_m : pin_in;
  endfunction

  function automatic logic [W-1:0] exp_out_en();
    return test_sel ? oe_m : '1;
  endfunction

  task automatic check(input bit ok, input string tag, input string ctx,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s (%s): actual=%h expected=%h at %0t", tag, ctx, act, exp, $time);
    end
  endtask

  // drive one cycle: set inputs, check outputs before the edge, advance model
  task automatic cycle(input logic [W-1:0] pi, input logic si, input logic sh,
                       input logic ce, input logic ue, input logic hz,
                       input logic ts, input string ctx);
    logic [W-1:0] cap_n;
    pin_in = pi; ser_in = si; shift_sel = sh; cap_en = ce;
    upd_en = ue; hiz_req = hz; test_sel = ts;
    #2;
    check(pin_out == exp_pin_out(), ts ? "R7" : "R2", ctx, pin_out, exp_pin_out());
    check(ser_out == cap_m[W-1], "R8", ctx, {{(W-1){1'b0}}, ser_out},
          {{(W-1){1'b0}}, cap_m[W-1]});
    check(out_en == exp_out_en(), "R9", ctx, out_en, exp_out_en());
    @(posedge clk);
    cap_n = cap_m;
    if (ce) cap_n = sh ? {cap_m[W-2:0], si} : pi;
    if (ue) begin
      upd_m = cap_m;
      oe_m  = hz ? '0 : '1;
    end
    cap_m = cap_n;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] pat;
    logic [W-1:0] seen;
    logic [W-1:0] held;
    void'($urandom(32'd1234));
    cap_m = '0; upd_m = '0; oe_m = '1;
    rst_n = 1'b0;
    pin_in = 8'h3C; ser_in = 1'b1; shift_sel = 1'b1; cap_en = 1'b0;
    upd_en = 1'b0; hiz_req = 1'b0; test_sel = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state visible in test mode
    check(pin_out == '0, "R1", "reset drive", pin_out, '0);
    check(out_en == '1, "R1", "reset enable", out_en, '1);
    check(ser_out == 1'b0, "R1", "reset serial", {7'd0, ser_out}, '0);
    rst_n = 1'b1;
    repeat (3) cycle(8'h3C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R1 after release");

    // R3: walk a pattern in, then out
    pat = 8'b1011_0010;
    for (int i = 0; i < W; i++) cycle(8'h00, pat[i], 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3 shift in");
    seen = '0;
    for (int i = 0; i < W; i++) begin
      seen[i] = ser_out;
      cycle(8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3 shift out");
    end
    check(seen == pat, "R3", "first-in order", seen, pat);

    // R4: capture then shift out
    cycle(8'hA5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R4 capture");
    seen = '0;
    for (int i = 0; i < W; i++) begin
      seen[W-1-i] = ser_out;
      cycle(8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4 read");
    end
    check(seen == 8'hA5, "R4", "captured word", seen, 8'hA5);

    // R5: enable low, nothing moves
    cycle(8'h5A, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 load");
    for (int i = 0; i < 6; i++)
      cycle(8'($urandom), 1'($urandom), 1'($urandom), 1'b0, 1'b0, 1'b0, 1'b0, "R5 hold");
    check(cap_m == 8'h5A, "R5", "model hold", cap_m, 8'h5A);

    // R6/R7: update, then drive while shifting
    cycle(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R6 update");
    held = pin_out;
    check(held == 8'h5A, "R6", "updated drive", held, 8'h5A);
    for (int i = 0; i < W; i++)
      cycle(8'($urandom), 1'($urandom), 1'($urandom), 1'b1, 1'b0, 1'b0, 1'b1, "R7 shift under drive");
    check(pin_out == held, "R7", "drive unchanged", pin_out, held);

    // R10: both enables on one edge
    cycle(8'hC3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R10 preload");
    cycle(8'h0F, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R10 same edge");
    check(pin_out == 8'hC3, "R10", "old capture used", pin_out, 8'hC3);

    // R9: output-enable latched by update, held through shifting
    cycle(8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R9 inactive");
    check(out_en == '0, "R9", "inactive", out_en, '0);
    for (int i = 0; i < 4; i++)
      cycle(8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R9 hold");
    check(out_en == '0, "R9", "still inactive", out_en, '0);
    cycle(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9 normal mode");
    check(out_en == '1, "R9", "normal enables", out_en, '1);

    // random mix
    for (int i = 0; i < 3000; i++)
      cycle(8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'(($urandom % 4) == 0),
            1'($urandom), 1'($urandom), "random");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule